// File: doc/BRIEF.md
# Two-Field Weave Deinterlacer Controller

This block turns a stream of interlaced 525-line video into a progressive raster by weaving the two fields together. On the input side it receives one sample per cycle. Each sample comes with a valid strobe, a field flag and the absolute line number. Only a fixed window of lines in each field is kept. Lines of the first (odd) field go into store A and lines of the second (even) field go into store B. The vertical blanking lines and any cycles without a valid strobe are dropped.

On the output side a raster engine asks for samples one at a time. The block walks the progressive lines in order and takes them from the two stores in turn: even-numbered output lines come from store A and odd-numbered ones from store B. The result is a frame with twice as many lines as one field. Each returned sample carries a valid flag one cycle after its request. The block pulses a completion flag on the final sample of the frame.

Top module: `dil_weave_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` and `frame_done` are low.
- R2: With `in_field` low (odd field), a valid sample on input line n, where ODD_FIRST <= n < ODD_FIRST+FIELD_LINES (13 to 252 by default), is stored in store A at row n-ODD_FIRST.
- R3: With `in_field` high (even field), a valid sample on input line n, where EVEN_FIRST <= n < EVEN_FIRST+FIELD_LINES (267 to 506 by default), is stored in store B at row n-EVEN_FIRST.
- R4: Samples on lines outside a field's window never change either store, even when their valid strobe is high.
- R5: A cycle with `in_valid` low writes nothing and does not advance the write address.
- R6: The write address returns to 0 at the first valid sample after the input has been outside the window. It then grows by one per stored sample, so column c of row r sits at address r*SAMPLES+c.
- R7: Output line 2k, column c returns column c of row k of store A. Output line 2k+1, column c returns column c of row k of store B. Columns and lines advance in order, giving 2*FIELD_LINES output lines.
- R8: `out_valid` is high in the cycle after each `rd_req` and low otherwise, and `out_data` holds the requested sample in that cycle.
- R9: `frame_done` is high for exactly one cycle, together with `out_valid`, for the last column of output line 2*FIELD_LINES-1. The next request then reads line 0, column 0.
- R10: A pulse on `rd_line_start` with no request in the same cycle makes the next request read column 0 of the current output line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_field | input | 1 | Field flag: 0 odd field, 1 even field |
| in_line | input | LINE_W (10) | Absolute input line number, 1 to 525 |
| in_data | input | DW (16) | Input sample |
| rd_line_start | input | 1 | Restart the column of the current output line |
| rd_req | input | 1 | Request the next output sample |
| out_data | output | DW (16) | Output sample |
| out_valid | output | 1 | Output sample valid, one cycle after a request |
| frame_done | output | 1 | Marks the last sample of the woven frame |

## Verification
The assertions assume that `in_field` stays steady for a whole field and matches the line numbering. They also assume that every windowed line carries exactly SAMPLES valid samples, and that `rd_line_start` never arrives in the same cycle as `rd_req`. The stimulus builds each field line by line with exactly SAMPLES strobed samples. Between samples it inserts idle cycles that carry junk data. It drives blanking lines with the strobe high and never raises the line restart together with a request. Every stored sample encodes its field, line and column, so any misplaced write or read shows up as a wrong value at the output.

// File: rtl/dil_pkg.sv
package dil_pkg;
  localparam int LINE_W = 10;
  typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_sel_e;
endpackage

// File: rtl/dil_field_ram.sv
module dil_field_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 960,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dil_write_ctrl.sv
module dil_write_ctrl
  import dil_pkg::*;
#(
  parameter int SAMPLES     = 4,
  parameter int FIELD_LINES = 240,
  parameter int ODD_FIRST   = 13,
  parameter int EVEN_FIRST  = 267,
  parameter int AW          = $clog2(SAMPLES*FIELD_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_field,
  input  logic [LINE_W-1:0] in_line,
  output logic              we_a,
  output logic              we_b,
  output logic [AW-1:0]     waddr
);
  localparam int DEPTH = SAMPLES * FIELD_LINES;
  localparam logic [LINE_W-1:0] ODD_LO  = LINE_W'(ODD_FIRST);
  localparam logic [LINE_W-1:0] ODD_HI  = LINE_W'(ODD_FIRST + FIELD_LINES - 1);
  localparam logic [LINE_W-1:0] EVEN_LO = LINE_W'(EVEN_FIRST);
  localparam logic [LINE_W-1:0] EVEN_HI = LINE_W'(EVEN_FIRST + FIELD_LINES - 1);

  logic          in_win, start, we;
  logic          armed;
  logic [AW:0]   ptr;

  always_comb begin
    if (in_field == BUF_B) in_win = (in_line >= EVEN_LO) && (in_line <= EVEN_HI);
    else                   in_win = (in_line >= ODD_LO)  && (in_line <= ODD_HI);
    start = in_valid && in_win && armed;
    we    = in_valid && in_win && (start || (ptr < (AW+1)'(DEPTH)));
    waddr = start ? '0 : ptr[AW-1:0];
    we_a  = we && (in_field == BUF_A);
    we_b  = we && (in_field == BUF_B);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      ptr   <= '0;
    end else if (!in_win) begin
      armed <= 1'b1;
    end else if (we) begin
      armed <= 1'b0;
      ptr   <= (AW+1)'(waddr) + 1'b1;
    end
  end

  p_addr_bound_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr < AW'(DEPTH)));
endmodule

// File: rtl/dil_read_seq.sv
module dil_read_seq #(
  parameter int SAMPLES     = 4,
  parameter int FIELD_LINES = 240,
  parameter int AW          = $clog2(SAMPLES*FIELD_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          req,
  output logic [AW-1:0] rd_addr,
  output logic          rd_sel,
  output logic          last_sample
);
  localparam int OUT_LINES = 2 * FIELD_LINES;
  localparam int OL_W      = $clog2(OUT_LINES);
  localparam int CW        = $clog2(SAMPLES);

  logic [OL_W-1:0] line_q;
  logic [CW-1:0]   col_q;
  logic            col_last, line_last;

  assign col_last    = (col_q == CW'(SAMPLES - 1));
  assign line_last   = (line_q == OL_W'(OUT_LINES - 1));
  assign last_sample = col_last && line_last;
  assign rd_sel      = line_q[0];
  assign rd_addr     = AW'(line_q[OL_W-1:1]) * AW'(SAMPLES) + AW'(col_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      col_q  <= '0;
    end else if (line_start) begin
      col_q <= '0;
    end else if (req) begin
      if (col_last) begin
        col_q  <= '0;
        line_q <= line_last ? '0 : line_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  p_col_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (line_start && !req) |=> (rd_addr == AW'($past(line_q[OL_W-1:1])) * AW'(SAMPLES)));
endmodule

// File: rtl/dil_weave_top.sv
module dil_weave_top
  import dil_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SAMPLES     = 4,
  parameter int FIELD_LINES = 240,
  parameter int ODD_FIRST   = 13,
  parameter int EVEN_FIRST  = 267
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_field,
  input  logic [LINE_W-1:0] in_line,
  input  logic [DW-1:0]     in_data,
  input  logic              rd_line_start,
  input  logic              rd_req,
  output logic [DW-1:0]     out_data,
  output logic              out_valid,
  output logic              frame_done
);
  localparam int DEPTH = SAMPLES * FIELD_LINES;
  localparam int AW    = $clog2(DEPTH);

  logic          we_v [2];
  logic [DW-1:0] rdata_v [2];
  logic [AW-1:0] waddr, raddr;
  logic          rsel, last_sample, sel_q;

  dil_write_ctrl #(
    .SAMPLES(SAMPLES), .FIELD_LINES(FIELD_LINES),
    .ODD_FIRST(ODD_FIRST), .EVEN_FIRST(EVEN_FIRST), .AW(AW)
  ) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_field(in_field),
    .in_line(in_line), .we_a(we_v[0]), .we_b(we_v[1]), .waddr(waddr)
  );

  dil_read_seq #(
    .SAMPLES(SAMPLES), .FIELD_LINES(FIELD_LINES), .AW(AW)
  ) u_rd (
    .clk(clk), .rst(rst), .line_start(rd_line_start), .req(rd_req),
    .rd_addr(raddr), .rd_sel(rsel), .last_sample(last_sample)
  );

  for (genvar g = 0; g < 2; g++) begin : g_store
    dil_field_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk(clk), .we(we_v[g]), .waddr(waddr), .wdata(in_data),
      .re(rd_req && (rsel == g[0])), .raddr(raddr), .rdata(rdata_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      frame_done <= 1'b0;
      sel_q      <= 1'b0;
    end else begin
      out_valid  <= rd_req;
      frame_done <= rd_req && !rd_line_start && last_sample;
      if (rd_req) sel_q <= rsel;
    end
  end

  assign out_data = (sel_q == BUF_B) ? rdata_v[1] : rdata_v[0];

  p_wr_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (we_v[0] || we_v[1]) |-> in_valid);
  p_buf_a_odd_r2: assert property (@(posedge clk) disable iff (rst)
    we_v[0] |-> (in_field == BUF_A));
  p_buf_b_even_r3: assert property (@(posedge clk) disable iff (rst)
    we_v[1] |-> (in_field == BUF_B));
  p_valid_follows_req_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> out_valid);
  p_valid_only_req_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !out_valid);
  p_done_with_valid_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> out_valid);
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
endmodule

// File: tb/test_dil_weave_top.sv
module test_dil_weave_top;
  localparam int CLK_PERIOD  = 10;
  localparam int DW          = 16;
  localparam int SAMPLES     = 4;
  localparam int FIELD_LINES = 240;
  localparam int ODD_FIRST   = 13;
  localparam int EVEN_FIRST  = 267;
  localparam int OUT_LINES   = 2 * FIELD_LINES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_field = 1'b0;
  logic [9:0] in_line = '0;
  logic [DW-1:0] in_data = '0;
  logic rd_line_start = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] out_data;
  logic out_valid, frame_done;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dil_weave_top #(
    .DW(DW), .SAMPLES(SAMPLES), .FIELD_LINES(FIELD_LINES),
    .ODD_FIRST(ODD_FIRST), .EVEN_FIRST(EVEN_FIRST)
  ) i_dil_weave_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_field(in_field),
    .in_line(in_line), .in_data(in_data), .rd_line_start(rd_line_start),
    .rd_req(rd_req), .out_data(out_data), .out_valid(out_valid),
    .frame_done(frame_done)
  );

  function automatic logic [DW-1:0] pat(input int f, input int ln, input int c);
    return DW'((f << 15) | (ln << 5) | c);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_line(input int f, input int ln);
    for (int c = 0; c < SAMPLES; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_field = f[0]; in_line = 10'(ln); in_data = pat(f, ln, c);
      @(negedge clk);
      in_valid = 1'b0; in_data = 16'hDEAD;
    end
  endtask

  // R2 R3 R4 R5 R6: both fields sent in full, blanking lines strobed too
  task automatic t_load_fields();
    for (int ln = 4; ln <= 265; ln++) send_line(0, ln);
    for (int ln = 266; ln <= 525; ln++) send_line(1, ln);
    for (int ln = 1; ln <= 3; ln++) send_line(1, ln);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {15'b0, out_valid}, 16'd0);
    check("R1 frame_done in reset", {15'b0, frame_done}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", {15'b0, out_valid}, 16'd0);
    check("R1 frame_done after reset", {15'b0, frame_done}, 16'd0);
  endtask

  task automatic t_idle();
    repeat (3) begin
      @(negedge clk);
      check("R8 no valid without request", {15'b0, out_valid}, 16'd0);
    end
  endtask

  task automatic read_one(input int ol, input int c, input string tag);
    int f, k, src;
    f = ol % 2; k = ol / 2;
    src = (f == 0) ? ODD_FIRST + k : EVEN_FIRST + k;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check({tag, " R7 data"}, out_data, pat(f, src, c));
    check("R8 out_valid after request", {15'b0, out_valid}, 16'd1);
    check("R9 frame_done", {15'b0, frame_done},
          16'((ol == OUT_LINES-1 && c == SAMPLES-1) ? 1 : 0));
  endtask

  task automatic t_read_frame();
    for (int ol = 0; ol < OUT_LINES; ol++)
      for (int c = 0; c < SAMPLES; c++)
        read_one(ol, c, (ol % 2 == 0) ? "R2 R4 R6 store A" : "R3 R4 R6 store B");
  endtask

  // R10: partial line, restart, then the whole frame again (also R9 wrap)
  task automatic t_restart_line();
    read_one(0, 0, "R9 wrap to line 0");
    read_one(0, 1, "R10 before restart");
    @(negedge clk); rd_line_start = 1'b1;
    @(negedge clk); rd_line_start = 1'b0;
    check("R10 no valid on restart", {15'b0, out_valid}, 16'd0);
    read_one(0, 0, "R10 column restarted");
    for (int c = 1; c < SAMPLES; c++) read_one(0, c, "R10 line continues");
    for (int ol = 1; ol < OUT_LINES; ol++)
      for (int c = 0; c < SAMPLES; c++)
        read_one(ol, c, "R5 R7 second frame");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_load_fields();
    t_idle();
    t_read_frame();
    t_restart_line();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule